// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block gathers up to 32 interrupt sources into two request lines for a processor. Each source passes through a two-stage synchroniser. It is then judged by its own trigger mode and polarity: level, active-high or active-low, or edge, rising or falling. A detected event sets a sticky bit in the status register. An enable register masks the status bits. A per-source routing register chooses whether an enabled, pending source raises the normal request or the critical request.

Software reaches the bank through a single-cycle register port. The port has a 3-bit offset, a write strobe with write data, and a combinational read path. Pending bits are acknowledged by writing ones to the status register. A level source that is still asserted after acknowledgement latches again, so the source must be serviced before it is acknowledged. Sources idle high: the inactive level for the reset polarity, which is active-low level, is logic 1.

Top module: `irq_regbank`

## Requirements
- R1: After reset, every register offset reads 0 and both request outputs are low, while all `irqIn` bits are held at 1.
- R2: Source n uses bit position 31-n in `irqIn` and in every register, so source 0 is bit 31.
- R3: With trigger bit 0 (level), a source whose input equals its polarity bit (1 = active-high, 0 = active-low) sets its status bit. The bit is visible three rising clock edges after the input change.
- R4: With trigger bit 1 (edge), a single input transition towards the polarity value sets the status bit once. Polarity 1 means a rising edge and polarity 0 means a falling edge. A transition the other way, or a change of polarity or trigger alone, sets nothing.
- R5: A write to offset 0 clears every status bit whose data bit is 1 and leaves the others unchanged. A status bit is never cleared in any other way.
- R6: A level source still at its active value when its status bit is cleared reads back as set after the clear.
- R7: When a clear write and a new event hit the same status bit on the same clock edge, the bit stays set.
- R8: Offset 5 reads status AND enable. Writes to offsets 5, 6 and 7 change nothing. Offsets 6 and 7 read 0.
- R9: `reqNonCrit` is the OR of the status AND enable bits whose routing bit is 0. `reqCrit` is the OR of those bits whose routing bit is 1.
- R10: Offsets 1 (enable), 2 (routing), 3 (polarity) and 4 (trigger) read back the last value written to them, and change only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Raw interrupt sources, source n on bit 31-n |
| wrEn | input | 1 | Register write strobe |
| regOffset | input | 3 | Register offset for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `regOffset`, combinational |
| reqNonCrit | output | 1 | Normal interrupt request |
| reqCrit | output | 1 | Critical interrupt request |

## Verification
A corrupted configuration register shows at once on its own read offset. It also shows on the request outputs the next time a source routed through it fires. A wrong status bit appears on offsets 0 and 5 in the same cycle it is latched. When enabled, it also reaches the request lines in that cycle. A flaw in the synchroniser or edge detector shows as a status bit that sets one cycle early or late, sets twice for one transition, or never sets. For that reason every input change is followed by reads at a fixed delay after it, and the clear-against-event collision is driven on the exact latching edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int OFFSET_W = 3;

  typedef enum logic [OFFSET_W-1:0] {
    OFF_STAT = 3'd0,
    OFF_ENA  = 3'd1,
    OFF_CRIT = 3'd2,
    OFF_POL  = 3'd3,
    OFF_TRIG = 3'd4,
    OFF_MASK = 3'd5,
    OFF_NONE = 3'd6
  } regSel_e;

  typedef struct packed {
    logic clrStat;
    logic ldEna;
    logic ldCrit;
    logic ldPol;
    logic ldTrig;
  } wrStrobe_t;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic                wrEn,
  input  logic [OFFSET_W-1:0] regOffset,
  output wrStrobe_t           strobe,
  output regSel_e             rdSel
);

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (regOffset)
        3'd0:    strobe.clrStat = 1'b1;
        3'd1:    strobe.ldEna   = 1'b1;
        3'd2:    strobe.ldCrit  = 1'b1;
        3'd3:    strobe.ldPol   = 1'b1;
        3'd4:    strobe.ldTrig  = 1'b1;
        default: strobe = '0;
      endcase
    end
  end

  always_comb begin
    case (regOffset)
      3'd0:    rdSel = OFF_STAT;
      3'd1:    rdSel = OFF_ENA;
      3'd2:    rdSel = OFF_CRIT;
      3'd3:    rdSel = OFF_POL;
      3'd4:    rdSel = OFF_TRIG;
      3'd5:    rdSel = OFF_MASK;
      default: rdSel = OFF_NONE;
    endcase
  end

endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int          WIDTH   = 32,
  parameter int          STAGES  = 2,
  parameter logic [31:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= RST_VAL[WIDTH-1:0];
        else       stageQ[s] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= RST_VAL[WIDTH-1:0];
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  wrStrobe_t          strobe,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] statQ,
  output logic [NUM_SRC-1:0] enaQ,
  output logic [NUM_SRC-1:0] critQ,
  output logic [NUM_SRC-1:0] polQ,
  output logic [NUM_SRC-1:0] trigQ,
  output logic               reqNonCrit,
  output logic               reqCrit
);

  localparam logic [31:0] IDLE_VAL = '1;

  logic [NUM_SRC-1:0] syncIn;
  logic [NUM_SRC-1:0] prevIn;
  logic [NUM_SRC-1:0] levelHit;
  logic [NUM_SRC-1:0] edgeHit;
  logic [NUM_SRC-1:0] srcEvent;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] pending;

  irq_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IDLE_VAL)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (irqIn),
    .dout(syncIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= IDLE_VAL[NUM_SRC-1:0];
    else       prevIn <= syncIn;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gDetect
    logic atPolarity;
    assign atPolarity  = ~(syncIn[g] ^ polQ[g]);
    assign levelHit[g] = ~trigQ[g] & atPolarity;
    assign edgeHit[g]  = trigQ[g] & (syncIn[g] ^ prevIn[g]) & atPolarity;
  end

  assign srcEvent = levelHit | edgeHit;
  assign clrMask  = strobe.clrStat ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
      enaQ  <= '0;
      critQ <= '0;
      polQ  <= '0;
      trigQ <= '0;
    end else begin
      statQ <= (statQ & ~clrMask) | srcEvent;
      if (strobe.ldEna)  enaQ  <= wrData;
      if (strobe.ldCrit) critQ <= wrData;
      if (strobe.ldPol)  polQ  <= wrData;
      if (strobe.ldTrig) trigQ <= wrData;
    end
  end

  assign pending    = statQ & enaQ;
  assign reqNonCrit = |(pending & ~critQ);
  assign reqCrit    = |(pending & critQ);

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  irqIn,
  input  logic                wrEn,
  input  logic [OFFSET_W-1:0] regOffset,
  input  logic [NUM_SRC-1:0]  wrData,
  output logic [NUM_SRC-1:0]  rdData,
  output logic                reqNonCrit,
  output logic                reqCrit
);

  wrStrobe_t          strobe;
  regSel_e            rdSel;
  logic [NUM_SRC-1:0] statQ;
  logic [NUM_SRC-1:0] enaQ;
  logic [NUM_SRC-1:0] critQ;
  logic [NUM_SRC-1:0] polQ;
  logic [NUM_SRC-1:0] trigQ;

  irq_ctrl u_ctrl (
    .wrEn     (wrEn),
    .regOffset(regOffset),
    .strobe   (strobe),
    .rdSel    (rdSel)
  );

  irq_datapath #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .strobe    (strobe),
    .wrData    (wrData),
    .statQ     (statQ),
    .enaQ      (enaQ),
    .critQ     (critQ),
    .polQ      (polQ),
    .trigQ     (trigQ),
    .reqNonCrit(reqNonCrit),
    .reqCrit   (reqCrit)
  );

  always_comb begin
    case (rdSel)
      OFF_STAT: rdData = statQ;
      OFF_ENA:  rdData = enaQ;
      OFF_CRIT: rdData = critQ;
      OFF_POL:  rdData = polQ;
      OFF_TRIG: rdData = trigQ;
      OFF_MASK: rdData = statQ & enaQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [2:0]         regOffset,
  input logic [NUM_SRC-1:0] wrData,
  input logic [NUM_SRC-1:0] statQ,
  input logic [NUM_SRC-1:0] enaQ,
  input logic [NUM_SRC-1:0] critQ,
  input logic [NUM_SRC-1:0] polQ,
  input logic [NUM_SRC-1:0] trigQ,
  input logic               reqNonCrit,
  input logic               reqCrit
);

  logic               clrWrite;
  logic [NUM_SRC-1:0] allowedClr;
  assign clrWrite   = wrEn && (regOffset == 3'd0);
  assign allowedClr = clrWrite ? wrData : '0;

  // R5: a status bit may fall only where a clear write carried a 1
  a_r5_clear_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite || !clrWrite |=> (($past(statQ) & ~$past(allowedClr) & ~statQ) == '0));

  // R10: configuration registers hold unless their own offset is written
  a_r10_ena_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regOffset == 3'd1) |=> $stable(enaQ));
  a_r10_crit_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regOffset == 3'd2) |=> $stable(critQ));
  a_r10_pol_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regOffset == 3'd3) |=> $stable(polQ));
  a_r10_trig_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regOffset == 3'd4) |=> $stable(trigQ));

  // R9: no request leaves the block while every source is masked
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (enaQ == '0) |-> (!reqNonCrit && !reqCrit));

  // R9: the critical line needs an enabled source routed to it
  a_r9_crit_routed: assert property (@(posedge clk) disable iff (!rstN)
    reqCrit |-> ((critQ & enaQ) != '0));

endmodule

bind irq_regbank irq_regbank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .regOffset (regOffset),
  .wrData    (wrData),
  .statQ     (statQ),
  .enaQ      (enaQ),
  .critQ     (critQ),
  .polQ      (polQ),
  .trigQ     (trigQ),
  .reqNonCrit(reqNonCrit),
  .reqCrit   (reqCrit)
);

// File: tb/tb_irq_regbank.sv
module tb_irq_regbank;

  localparam int CLK_PERIOD = 20;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] irqIn = '1;
  logic         wrEn = 1'b0;
  logic [2:0]   regOffset = '0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData;
  logic         reqNonCrit;
  logic         reqCrit;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 0;

  logic [W-1:0] mStat = '0, mEna = '0, mCrit = '0, mPol = '0, mTrig = '0, mIn = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_regbank dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .regOffset(regOffset),
    .wrData(wrData), .rdData(rdData), .reqNonCrit(reqNonCrit), .reqCrit(reqCrit)
  );

  function automatic logic [W-1:0] levelActive(logic [W-1:0] inV, logic [W-1:0] pol,
                                               logic [W-1:0] trig);
    return ~trig & ~(inV ^ pol);
  endfunction

  function automatic logic [W-1:0] edgeFire(logic [W-1:0] oldV, logic [W-1:0] newV,
                                            logic [W-1:0] pol, logic [W-1:0] trig);
    return trig & (oldV ^ newV) & ~(newV ^ pol);
  endfunction

  function automatic logic [W-1:0] expRead(int off);
    case (off)
      0: return mStat;
      1: return mEna;
      2: return mCrit;
      3: return mPol;
      4: return mTrig;
      5: return mStat & mEna;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readOff(int off, output logic [W-1:0] val);
    regOffset = off[2:0];
    #1;
    val = rdData;
  endtask

  // Called just after a falling edge; all reads finish before the next rising edge.
  task automatic checkAll(string tag);
    logic [W-1:0] v;
    for (int off = 0; off < 8; off++) begin
      readOff(off, v);
      chk($sformatf("%s off%0d", tag, off), v, expRead(off));
    end
    chk({tag, " R9 nonCrit"}, {31'd0, reqNonCrit}, {31'd0, |(mStat & mEna & ~mCrit)});
    chk({tag, " R9 crit"}, {31'd0, reqCrit}, {31'd0, |(mStat & mEna & mCrit)});
  endtask

  task automatic writeReg(int off, logic [W-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; regOffset = off[2:0]; wrData = data;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    case (off)
      0: mStat = mStat & ~data;
      1: mEna = data;
      2: mCrit = data;
      3: mPol = data;
      4: mTrig = data;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    mStat |= levelActive(mIn, mPol, mTrig);
  endtask

  task automatic driveIn(logic [W-1:0] newIn);
    @(negedge clk);
    irqIn = newIn;
    mStat |= edgeFire(mIn, newIn, mPol, mTrig);
    mIn = newIn;
    repeat (4) @(posedge clk);
    @(negedge clk);
    mStat |= levelActive(mIn, mPol, mTrig);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vecCount++;
    errCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'h5eed_1c0d));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R1 reset");

    // R2/R4: source 0 (bit 31) as a rising-edge source
    writeReg(1, '1);
    writeReg(4, 32'h8000_0000);
    writeReg(3, 32'h8000_0000);
    checkAll("R4 no edge from config change");
    driveIn(32'h7fff_ffff);
    checkAll("R4 falling ignored");
    driveIn(32'hffff_ffff);
    readOff(0, v);
    chk("R2 source0 at bit31", v, 32'h8000_0000);
    checkAll("R4 rising sets");
    writeReg(0, 32'h8000_0000);
    checkAll("R5 clear edge bit");

    // R3/R6: source 5 (bit 26) active-low level
    driveIn(32'hfbff_ffff);
    readOff(0, v);
    chk("R3 level low latched", v, 32'h0400_0000);
    checkAll("R3 level");
    writeReg(0, 32'h0400_0000);
    readOff(0, v);
    chk("R6 relatch while active", v, 32'h0400_0000);
    driveIn(32'hffff_ffff);
    writeReg(0, 32'hffff_ffff);
    readOff(0, v);
    chk("R5 clear after release", v, 32'h0);

    // R9: route source 0 to critical
    writeReg(2, 32'h8000_0000);
    driveIn(32'h7fff_ffff);
    driveIn(32'hffff_ffff);
    checkAll("R9 critical route");

    // R7: clear lands on the same edge as a new rising event
    driveIn(32'h7fff_ffff);
    writeReg(0, '1);
    @(negedge clk);
    irqIn = 32'hffff_ffff;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b1; regOffset = 3'd0; wrData = 32'h8000_0000;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    mIn = irqIn;
    mStat |= 32'h8000_0000;
    readOff(0, v);
    chk("R7 event beats clear", v, 32'h8000_0000);

    // R8: writes to the read-only and unused offsets
    writeReg(5, 32'h0);
    writeReg(6, 32'h1234_5678);
    writeReg(7, 32'hffff_ffff);
    checkAll("R8 ignored writes");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom % 7;
      if (op < 3) driveIn(mIn ^ ($urandom & $urandom));
      else        writeReg($urandom % 8, $urandom);
      checkAll("R10 random");
    end

    finish_run();
  end

endmodule